// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block judges whether a recovered serial clock runs at the correct frequency relative to a local reference. The recovered clock is sixteen times the reference frequency, so it is divided by 16 and its divided edges are counted. Once per measurement window of 2^WIN_LOG2 reference cycles, that count is compared with the ideal count of 2^WIN_LOG2. All ppm figures are relative to the reference, so a reference that is itself slightly off does not upset the judgement. The lock flag drops when the error exceeds a wide threshold (2000 ppm). It returns only when the error falls inside a narrow threshold (500 ppm). Between the two it holds its value.

A mode-select output follows the lock flag through a hold filter. An external loop uses it to choose between frequency acquisition (select low) and phase tracking (select high). The lock decision depends only on the two clocks, so it stays valid when the loop is held in frequency-only mode. The divided count crosses into the reference domain as a registered Gray code through a synchroniser chain. The count of the most recent window is visible on a debug port.

The decision logic is a three-state machine:
- ST_IDLE is the state after reset, before any window has been judged.
- ST_HUNT means not locked.
- ST_LOCKED means locked.

Its transitions, each taken only at a window end, are:
- T_FIRST_LOCK: ST_IDLE to ST_LOCKED, when the error is inside the narrow threshold.
- T_FIRST_MISS: ST_IDLE to ST_HUNT, otherwise.
- T_ACQUIRE: ST_HUNT to ST_LOCKED, when the error is inside the narrow threshold and the count is nonzero.
- T_DROP: ST_LOCKED to ST_HUNT, when the error is beyond the wide threshold or the count is zero.

The select filter has two modes, MODE_FREQ and MODE_PHASE.

Top module: `freq_lock_detect`

## Requirements
- R1: While reset is high, lock and sel are 0. After reset is released, lock stays 0 until the first window end, at reference edge 2^WIN_LOG2.
- R2: At each window end, dbg_count takes the number of divided recovered-clock cycles in the last 2^WIN_LOG2 reference cycles. That number is within 1 of 2^WIN_LOG2·f_rec/(16·f_ref). dbg_count changes at no other time.
- R3: In ST_LOCKED, a window whose absolute deviation from 2^WIN_LOG2 exceeds round(2^WIN_LOG2·2000/10^6) makes lock 0. That bound is 66 counts at the default and 8 at WIN_LOG2=12.
- R4: From not-locked, lock becomes 1 only after a window with a nonzero count whose deviation is at most round(2^WIN_LOG2·500/10^6). That bound is 16 counts at the default and 2 at WIN_LOG2=12.
- R5: A window whose deviation lies between the two thresholds leaves lock unchanged, whether it is 1 or 0.
- R6: A window count of zero, as when the recovered clock stops, forces lock to 0.
- R7: lock changes only on reference edge k·2^WIN_LOG2 after reset release, for some k ≥ 1.
- R8: sel takes lock's new value exactly SEL_HOLD (64) reference edges after lock changes, once lock has held that value for SEL_HOLD consecutive cycles.
- R9: sel = 0 selects frequency acquisition and sel = 1 selects phase tracking. A change of sel always moves it to the current lock value, so after settling sel equals lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rec | input | 1 | Recovered clock, nominally 16× the reference |
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| lock | output | 1 | Frequency lock flag |
| sel | output | 1 | Loop mode: 0 frequency acquisition, 1 phase tracking |
| dbg_count | output | WIN_LOG2+2 | Divided-clock count of the last complete window |

## Verification
The assertions assume that reset is applied and released for both clock domains together. They also assume that a window's count never wraps the WIN_LOG2+2 bit counter, which needs the recovered clock to stay below four times its nominal rate. The Gray-step property assumes the recovered-domain counter advances by one divided cycle at a time. The stimulus holds the reference fixed and sets the recovered clock to offsets between -2500 and +2500 ppm, or stops it altogether. Every frequency step is held for two full windows plus the select hold time, so each judged window sees a single frequency.

// File: rtl/flk_pkg.sv
package flk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    typedef enum logic {
        MODE_FREQ  = 1'b0,
        MODE_PHASE = 1'b1
    } sel_mode_e;

    // Rounded count threshold for a ppm figure over a window of 2^win_log2 counts.
    function automatic longint ppm_to_counts(input int win_log2, input int ppm);
        longint expect_c;
        expect_c = longint'(1) << win_log2;
        return (expect_c * longint'(ppm) + 64'sd500000) / 64'sd1000000;
    endfunction
endpackage

// File: rtl/flk_rec_count.sv
module flk_rec_count #(
    parameter int CNT_W    = 17,
    parameter int DIV_LOG2 = 4
) (
    input  logic             clk_rec,
    input  logic             rst,
    output logic [CNT_W-1:0] div_gray
);
    localparam int TOT_W = CNT_W + DIV_LOG2;

    logic [TOT_W-1:0] edge_q;
    logic [TOT_W-1:0] edge_d;
    logic [CNT_W-1:0] div_d;

    assign edge_d = edge_q + TOT_W'(1);
    assign div_d  = edge_d[TOT_W-1:DIV_LOG2];

    always_ff @(posedge clk_rec or posedge rst) begin
        if (rst) begin
            edge_q   <= '0;
            div_gray <= '0;
        end else begin
            edge_q   <= edge_d;
            div_gray <= div_d ^ (div_d >> 1);
        end
    end

    // R2: the crossing word moves one Gray step at a time
    assert_gray_step_R2: assert property (@(posedge clk_rec) disable iff (rst)
        !$stable(div_gray) |-> $countones(div_gray ^ $past(div_gray)) == 1);
endmodule

// File: rtl/flk_ref_capture.sv
module flk_ref_capture #(
    parameter int CNT_W       = 17,
    parameter int WIN_LOG2    = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic [CNT_W-1:0] div_gray,
    output logic             win_end,
    output logic [CNT_W-1:0] win_count,
    output logic [CNT_W-1:0] meas_q
);
    logic [CNT_W-1:0]    sync_q [SYNC_STAGES];
    logic [CNT_W-1:0]    cur_bin;
    logic [CNT_W-1:0]    snap_q;
    logic [WIN_LOG2-1:0] tick_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk_ref or posedge rst) begin
            if (rst) begin
                sync_q[g] <= '0;
            end else if (g == 0) begin
                sync_q[g] <= div_gray;
            end else begin
                sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            cur_bin[i] = ^(sync_q[SYNC_STAGES-1] >> i);
        end
    end

    assign win_end   = &tick_q;
    assign win_count = cur_bin - snap_q;

    always_ff @(posedge clk_ref or posedge rst) begin
        if (rst) begin
            tick_q <= '0;
            snap_q <= '0;
            meas_q <= '0;
        end else begin
            tick_q <= tick_q + WIN_LOG2'(1);
            if (win_end) begin
                snap_q <= cur_bin;
                meas_q <= win_count;
            end
        end
    end

    // R2: the published count moves only at a window end
    assert_meas_at_window_R2: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(meas_q) |-> $past(win_end));
endmodule

// File: rtl/flk_lock_fsm.sv
module flk_lock_fsm
    import flk_pkg::*;
#(
    parameter int CNT_W      = 17,
    parameter int WIN_LOG2   = 15,
    parameter int UNLOCK_PPM = 2000,
    parameter int RELOCK_PPM = 500
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             win_end,
    input  logic [CNT_W-1:0] win_count,
    output logic             lock
);
    localparam longint           EXPECT_L = longint'(1) << WIN_LOG2;
    localparam logic [CNT_W-1:0] EXP_C    = CNT_W'(EXPECT_L);
    localparam logic [CNT_W-1:0] WIDE_C   = CNT_W'(ppm_to_counts(WIN_LOG2, UNLOCK_PPM));
    localparam logic [CNT_W-1:0] NARROW_C = CNT_W'(ppm_to_counts(WIN_LOG2, RELOCK_PPM));

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] dev;
    logic             starved, too_far, close_in;

    always_comb begin
        dev      = (win_count >= EXP_C) ? (win_count - EXP_C) : (EXP_C - win_count);
        starved  = (win_count == '0);
        too_far  = starved || (dev > WIDE_C);
        close_in = !starved && (dev <= NARROW_C);
    end

    always_ff @(posedge clk_ref or posedge rst) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_end) state_d = close_in ? ST_LOCKED : ST_HUNT; // T_FIRST_LOCK / T_FIRST_MISS
            ST_HUNT:   if (win_end && close_in) state_d = ST_LOCKED;          // T_ACQUIRE
            ST_LOCKED: if (win_end && too_far) state_d = ST_HUNT;             // T_DROP
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lock = (state_q == ST_LOCKED);
    end

    // R1: no decision leaves the idle state before a window end
    assert_idle_until_window_R1: assert property (@(posedge clk_ref) disable iff (rst)
        (state_q == ST_IDLE) && !win_end |=> (state_q == ST_IDLE));
    // R3: a wide deviation always clears lock
    assert_wide_unlock_R3: assert property (@(posedge clk_ref) disable iff (rst)
        win_end && (dev > WIDE_C) |=> !lock);
    // R4: lock rises only after a close, nonzero window
    assert_relock_narrow_R4: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(lock) |-> $past(win_end && close_in));
    // R6: a starved window clears lock
    assert_zero_unlock_R6: assert property (@(posedge clk_ref) disable iff (rst)
        win_end && starved |=> !lock);
    // R7: lock moves only right after a window end
    assert_lock_at_window_R7: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(lock) |-> $past(win_end));
endmodule

// File: rtl/flk_sel_filter.sv
module flk_sel_filter
    import flk_pkg::*;
#(
    parameter int SEL_HOLD = 64
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic lock,
    output logic sel
);
    localparam int               HOLD_W = $clog2(SEL_HOLD + 1);
    localparam logic [HOLD_W-1:0] LAST_C = HOLD_W'(SEL_HOLD - 1);

    sel_mode_e         mode_q, mode_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic              want_phase;

    assign want_phase = lock;

    always_comb begin
        mode_d = mode_q;
        hold_d = '0;
        unique case (mode_q)
            MODE_FREQ: if (want_phase) begin
                if (hold_q == LAST_C) mode_d = MODE_PHASE;
                else                  hold_d = hold_q + HOLD_W'(1);
            end
            MODE_PHASE: if (!want_phase) begin
                if (hold_q == LAST_C) mode_d = MODE_FREQ;
                else                  hold_d = hold_q + HOLD_W'(1);
            end
            default: mode_d = MODE_FREQ;
        endcase
    end

    always_ff @(posedge clk_ref or posedge rst) begin
        if (rst) begin
            mode_q <= MODE_FREQ;
            hold_q <= '0;
        end else begin
            mode_q <= mode_d;
            hold_q <= hold_d;
        end
    end

    always_comb begin
        sel = (mode_q == MODE_PHASE);
    end

    // R9: sel only ever moves to the current lock value
    assert_sel_agrees_R9: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(sel) |-> (sel == lock));
    // R8: sel moves only once the hold count is used up
    assert_sel_hold_R8: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(sel) |-> ($past(hold_q) == LAST_C));
endmodule

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
    parameter int WIN_LOG2    = 15,
    parameter int DIV_LOG2    = 4,
    parameter int UNLOCK_PPM  = 2000,
    parameter int RELOCK_PPM  = 500,
    parameter int SEL_HOLD    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_rec,
    input  logic                clk_ref,
    input  logic                rst,
    output logic                lock,
    output logic                sel,
    output logic [WIN_LOG2+1:0] dbg_count
);
    localparam int CNT_W = WIN_LOG2 + 2;

    logic [CNT_W-1:0] div_gray;
    logic [CNT_W-1:0] win_count;
    logic             win_end;

    flk_rec_count #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_rec (
        .clk_rec  (clk_rec),
        .rst      (rst),
        .div_gray (div_gray)
    );

    flk_ref_capture #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .div_gray  (div_gray),
        .win_end   (win_end),
        .win_count (win_count),
        .meas_q    (dbg_count)
    );

    flk_lock_fsm #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2),
                   .UNLOCK_PPM(UNLOCK_PPM), .RELOCK_PPM(RELOCK_PPM)) u_fsm (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .win_end   (win_end),
        .win_count (win_count),
        .lock      (lock)
    );

    flk_sel_filter #(.SEL_HOLD(SEL_HOLD)) u_sel (
        .clk_ref (clk_ref),
        .rst     (rst),
        .lock    (lock),
        .sel     (sel)
    );
endmodule

// File: tb/test_freq_lock_detect.sv
`timescale 1ps/1fs
module test_freq_lock_detect;
    localparam int WLOG   = 12;
    localparam int W      = 1 << WLOG;
    localparam int HOLD   = 64;
    localparam int SETTLE = 2 * W + 80;
    localparam int NSTEP  = 10;
    localparam int  STEP_PPM  [NSTEP] = '{0, 400, 1000, 2500, 1000, -400, -1000, -2500, -400, 0};
    localparam bit  STEP_LOCK [NSTEP] = '{1, 1, 1, 0, 0, 1, 1, 0, 1, 1};

    logic clk_rec = 1'b0;
    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic lock, sel;
    logic [WLOG+1:0] dbg_count;

    real rec_half = 125.0;
    bit  rec_run  = 1'b1;
    int  n_chk = 0;
    int  n_bad = 0;
    int  edge_n = 0;
    bit  done = 1'b0;

    freq_lock_detect #(.WIN_LOG2(WLOG)) i_freq_lock_detect (
        .clk_rec   (clk_rec),
        .clk_ref   (clk_ref),
        .rst       (rst),
        .lock      (lock),
        .sel       (sel),
        .dbg_count (dbg_count)
    );

    initial forever #2000 clk_ref = ~clk_ref;
    initial forever begin
        if (rec_run) begin
            #(rec_half) clk_rec = ~clk_rec;
        end else begin
            #2000;
        end
    end

    always @(posedge clk_ref) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_ppm(input int ppm);
        rec_half = 125.0 / (1.0 + real'(ppm) * 1.0e-6);
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic watch(input logic target, output int t_lock, output int t_sel);
        t_lock = -1;
        t_sel  = -1;
        for (int i = 0; i < 3 * W && t_sel < 0; i++) begin
            @(negedge clk_ref);
            if (t_lock < 0 && lock === target) t_lock = edge_n;
            if (t_sel < 0 && sel === target)   t_sel  = edge_n;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk_ref);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int  t_lock, t_sel;
        real exp_cnt;
        bit  prev_lock;
        string tag;

        // R1: reset state
        wait_ref(5);
        check(lock === 1'b0, "R1", "lock in reset", lock, 0);
        check(sel === 1'b0, "R1", "sel in reset", sel, 0);
        rst = 1'b0;
        wait_ref(W - 10);
        check(lock === 1'b0, "R1", "lock before first window", lock, 0);

        // Frequency sweep table: R2, R3, R4, R5, R9
        prev_lock = 1'b0;
        for (int s = 0; s < NSTEP; s++) begin
            set_ppm(STEP_PPM[s]);
            wait_ref(SETTLE);
            if (STEP_LOCK[s] == prev_lock) tag = "R5";
            else if (STEP_LOCK[s])         tag = "R4";
            else                           tag = "R3";
            check(lock === STEP_LOCK[s], tag, $sformatf("lock at %0d ppm", STEP_PPM[s]),
                  lock, STEP_LOCK[s]);
            check(sel === STEP_LOCK[s], "R9", $sformatf("sel at %0d ppm", STEP_PPM[s]),
                  sel, STEP_LOCK[s]);
            exp_cnt = real'(W) * (1.0 + real'(STEP_PPM[s]) * 1.0e-6);
            check((real'(dbg_count) - exp_cnt <= 1.0) && (exp_cnt - real'(dbg_count) <= 1.0),
                  "R2", $sformatf("count at %0d ppm", STEP_PPM[s]),
                  int'(dbg_count), int'(exp_cnt));
            prev_lock = STEP_LOCK[s];
        end

        // R7 and R8: falling edge timing
        set_ppm(2500);
        watch(1'b0, t_lock, t_sel);
        check(t_lock > 0 && (t_lock % W) == 0, "R7", "lock fall edge mod window", t_lock % W, 0);
        check(t_sel - t_lock == HOLD, "R8", "sel fall delay", t_sel - t_lock, HOLD);

        // R7 and R8: rising edge timing
        set_ppm(0);
        watch(1'b1, t_lock, t_sel);
        check(t_lock > 0 && (t_lock % W) == 0, "R7", "lock rise edge mod window", t_lock % W, 0);
        check(t_sel - t_lock == HOLD, "R8", "sel rise delay", t_sel - t_lock, HOLD);
        wait_ref(SETTLE);

        // R6: recovered clock stops
        rec_run = 1'b0;
        wait_ref(SETTLE);
        check(lock === 1'b0, "R6", "lock with stopped clock", lock, 0);
        check(dbg_count == '0, "R6", "count with stopped clock", int'(dbg_count), 0);
        check(sel === 1'b0, "R9", "sel with stopped clock", sel, 0);

        // R4: clock returns at nominal rate
        rec_run = 1'b1;
        wait_ref(SETTLE);
        check(lock === 1'b1, "R4", "relock after restart", lock, 1);
        check(sel === 1'b1, "R9", "sel after restart", sel, 1);

        done = 1'b1;
        finish_run();
    end
endmodule